// File: doc/BRIEF.md
# Guarded Clock-Source Select Register

This block holds the control state that decides which clock drives a periodic tick timer and which clock drives a watchdog timer. It also holds a two-bit modulation setting for a frequency synthesizer. Software reaches it over a byte-wide register bus. The write strobe is registered, and reads are combinational on the address. The clock multiplexers, the timers and the synthesizer all live outside the block. They consume its source codes, its modulation field and its restart pulses.

Two guards apply to selecting the oscillator clock. A select bit that names the external oscillator can only become 1 while the block's oscillator-up flag is set. The same bit is forced back to 0 in the cycle the flag drops. Each timer receives a one-cycle restart pulse whenever its effective source code changes. A change that is masked by an overriding select bit produces no pulse.

The oscillator-up flag and the synthesizer-lock flag are kept inside the block. External one-cycle set inputs raise them. An accepted write to the modulation register clears both flags.

Top module: `clksel_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register clears. After that edge, all outputs read 0 and `rdata_o` is 0 at every address.
- R2: The select register lives at address 0, with this layout: bit0 = low watchdog select, bit1 = tick source, bit2 = high watchdog select, bit3 = synthesizer select, and bits 7:4 read 0. A write of 1 to bit1 or bit0 takes effect only while `osc_up_o` is 1. At any other time the bit stays 0.
- R3: In the same cycle that `osc_up_o` becomes 0, the tick source bit and the low watchdog select bit become 0. `tick_src_o` is 0 for the internal RC clock and 1 for the oscillator clock.
- R4: Every change of `tick_src_o` is accompanied by a one-cycle pulse on `tick_restart_o` in the same cycle. No pulse occurs without a change.
- R5: `wdog_src_o` decodes as follows: 0 (internal RC) when high=0 and low=0, 1 (oscillator) when high=0 and low=1, and 2 (auxiliary) whenever high=1.
- R6: `wdog_restart_o` pulses for one cycle exactly when `wdog_src_o` changes. Toggling the low bit while the high bit is 1 gives no pulse.
- R7: The modulation register lives at address 1. Only bits 1:0 are stored, and they drive `pll_mod_o`. Bits 7:2 read 0.
- R8: A write to address 1 is ignored while `prot_i` is 1 or while the synthesizer select bit is 0.
- R9: An accepted write to address 1 clears `osc_up_o` and `pll_lock_o` after the edge. The clear wins over a set input in the same cycle.
- R10: A one-cycle pulse on `osc_set_i` or `lock_set_i` sets `osc_up_o` or `pll_lock_o` at the next edge.
- R11: Addresses 2 and 3 read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| prot_i | input | 1 | Write protection for the modulation register |
| osc_set_i | input | 1 | Sets the oscillator-up flag |
| lock_set_i | input | 1 | Sets the synthesizer-lock flag |
| tick_src_o | output | 1 | Tick timer source code |
| wdog_src_o | output | 2 | Watchdog source code |
| tick_restart_o | output | 1 | Tick timer restart pulse |
| wdog_restart_o | output | 1 | Watchdog restart pulse |
| pll_mod_o | output | 2 | Modulation field |
| pll_sel_o | output | 1 | Synthesizer select bit |
| osc_up_o | output | 1 | Oscillator-up flag |
| pll_lock_o | output | 1 | Synthesizer-lock flag |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is an accepted modulation write and a flag set pulse. The second pair is the forced clear of the oscillator selections and the restart pulses that this clear causes. The bench provokes both pairs with a single modulation write issued while `osc_set_i` and `lock_set_i` are high and the low watchdog select is active. It then judges that both flags read 0, that the low select has dropped, and that `wdog_restart_o` pulses once in that same cycle. A second modulation write, made while the high select is set, checks that the forced clear gives a tick restart but no watchdog restart.

// File: rtl/clksel_pkg.sv
// Package: shared codes and bit positions for the clock-source select block.
// Assumes: the watchdog source code is consumed by an external multiplexer.
package clksel_pkg;
    typedef enum logic [1:0] {
        WD_SRC_RC  = 2'd0,
        WD_SRC_OSC = 2'd1,
        WD_SRC_AUX = 2'd2
    } wd_src_e;

    localparam int BIT_WD_LO = 0;
    localparam int BIT_TICK  = 1;
    localparam int BIT_WD_HI = 2;
    localparam int BIT_PSEL  = 3;
    localparam int SEL_W     = 4;
endpackage

// File: rtl/clksel_flags.sv
// Module: holds the oscillator-up and synthesizer-lock status flags.
// Assumes: set inputs are single-cycle pulses, and clr_i is an accepted
// modulation write, which has priority over both set inputs.
module clksel_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic osc_set_i,
    input  logic lock_set_i,
    output logic osc_up_o,
    output logic osc_up_nxt_o,
    output logic lock_o
);
    logic lock_nxt;

    // Next flag values: a clear overrides a set.
    always_comb begin
        osc_up_nxt_o = clr_i ? 1'b0 : (osc_set_i  | osc_up_o);
        lock_nxt     = clr_i ? 1'b0 : (lock_set_i | lock_o);
    end

    // Flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osc_up_o <= 1'b0;
            lock_o   <= 1'b0;
        end else begin
            osc_up_o <= osc_up_nxt_o;
            lock_o   <= lock_nxt;
        end
    end

    p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!osc_up_o && !lock_o));

    p_set_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && osc_set_i) |=> osc_up_o);
endmodule

// File: rtl/clksel_select.sv
// Module: the select register. It keeps the tick and watchdog source bits
// and the synthesizer select, and derives the restart pulses.
// Assumes: osc_up_i is the present flag and osc_up_nxt_i its value after
// this edge, both from clksel_flags.
module clksel_select
    import clksel_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [SEL_W-1:0] wdata_i,
    input  logic             osc_up_i,
    input  logic             osc_up_nxt_i,
    output logic             tick_src_o,
    output wd_src_e          wd_src_o,
    output logic             tick_restart_o,
    output logic             wd_restart_o,
    output logic             pll_sel_o,
    output logic [SEL_W-1:0] sel_rd_o
);
    logic    tick_q, lo_q, hi_q;
    logic    tick_w, lo_w, hi_n, psel_n;
    logic    tick_n, lo_n;
    wd_src_e wd_n, wd_q;

    // Written values: oscillator bits are accepted only while the oscillator is up.
    always_comb begin
        tick_w = wr_i ? (wdata_i[BIT_TICK]  & osc_up_i) : tick_q;
        lo_w   = wr_i ? (wdata_i[BIT_WD_LO] & osc_up_i) : lo_q;
        hi_n   = wr_i ? wdata_i[BIT_WD_HI] : hi_q;
        psel_n = wr_i ? wdata_i[BIT_PSEL]  : pll_sel_o;
        tick_n = tick_w & osc_up_nxt_i;
        lo_n   = lo_w   & osc_up_nxt_i;
        wd_n   = hi_n ? WD_SRC_AUX : (lo_n ? WD_SRC_OSC : WD_SRC_RC);
    end

    // Select bits, decoded watchdog code and restart pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q         <= 1'b0;
            lo_q           <= 1'b0;
            hi_q           <= 1'b0;
            pll_sel_o      <= 1'b0;
            wd_q           <= WD_SRC_RC;
            tick_restart_o <= 1'b0;
            wd_restart_o   <= 1'b0;
        end else begin
            tick_q         <= tick_n;
            lo_q           <= lo_n;
            hi_q           <= hi_n;
            pll_sel_o      <= psel_n;
            wd_q           <= wd_n;
            tick_restart_o <= (tick_n != tick_q);
            wd_restart_o   <= (wd_n != wd_q);
        end
    end

    // Outputs and readback image.
    always_comb begin
        tick_src_o          = tick_q;
        wd_src_o            = wd_q;
        sel_rd_o            = '0;
        sel_rd_o[BIT_WD_LO] = lo_q;
        sel_rd_o[BIT_TICK]  = tick_q;
        sel_rd_o[BIT_WD_HI] = hi_q;
        sel_rd_o[BIT_PSEL]  = pll_sel_o;
    end

    p_refused_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !osc_up_i) |=> !tick_q);

    p_forced_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_up_i |-> (!tick_q && !lo_q));

    p_tick_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_restart_o == (tick_q != $past(tick_q)));

    p_wd_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_q && $past(hi_q)) |-> !wd_restart_o);
endmodule

// File: rtl/clksel_pll.sv
// Module: the modulation register and its write guard.
// Assumes: wr_i is already decoded to this register's address.
module clksel_pll #(
    parameter int MOD_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             prot_i,
    input  logic             pll_sel_i,
    input  logic [MOD_W-1:0] wdata_i,
    output logic [MOD_W-1:0] mod_o,
    output logic             accept_o
);
    // A write is accepted only when protection is off and the synthesizer is selected.
    always_comb accept_o = wr_i && !prot_i && pll_sel_i;

    // Modulation field register.
    always_ff @(posedge clk) begin
        if (!rst_n)        mod_o <= '0;
        else if (accept_o) mod_o <= wdata_i;
    end

    p_guarded_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (prot_i || !pll_sel_i)) |=> $stable(mod_o));

    p_write_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !prot_i && pll_sel_i) |=> (mod_o == $past(wdata_i)));
endmodule

// File: rtl/clksel_ctrl.sv
// Module: top of the clock-source select block. It decodes register
// accesses, wires the flag, select and modulation parts, and muxes readback.
// Assumes: DATA_W covers the select layout, and the addresses differ and fit ADDR_W.
module clksel_ctrl
    import clksel_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int DATA_W   = 8,
    parameter int MOD_W    = 2,
    parameter int SEL_ADDR = 0,
    parameter int MOD_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              prot_i,
    input  logic              osc_set_i,
    input  logic              lock_set_i,
    output logic              tick_src_o,
    output logic [1:0]        wdog_src_o,
    output logic              tick_restart_o,
    output logic              wdog_restart_o,
    output logic [MOD_W-1:0]  pll_mod_o,
    output logic              pll_sel_o,
    output logic              osc_up_o,
    output logic              pll_lock_o
);
    localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(SEL_ADDR);
    localparam logic [ADDR_W-1:0] A_MOD = ADDR_W'(MOD_ADDR);

    logic             hit_sel, hit_mod, accept, osc_nxt;
    logic [SEL_W-1:0] sel_rd;
    wd_src_e          wd_src;
    logic             wdata_unused;

    // Address decode for the write strobe.
    always_comb begin
        hit_sel      = wr_en_i && (addr_i == A_SEL);
        hit_mod      = wr_en_i && (addr_i == A_MOD);
        wdata_unused = ^wdata_i[DATA_W-1:SEL_W];
    end

    clksel_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (accept),
        .osc_set_i    (osc_set_i),
        .lock_set_i   (lock_set_i),
        .osc_up_o     (osc_up_o),
        .osc_up_nxt_o (osc_nxt),
        .lock_o       (pll_lock_o)
    );

    clksel_select u_select (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_i           (hit_sel),
        .wdata_i        (wdata_i[SEL_W-1:0]),
        .osc_up_i       (osc_up_o),
        .osc_up_nxt_i   (osc_nxt),
        .tick_src_o     (tick_src_o),
        .wd_src_o       (wd_src),
        .tick_restart_o (tick_restart_o),
        .wd_restart_o   (wdog_restart_o),
        .pll_sel_o      (pll_sel_o),
        .sel_rd_o       (sel_rd)
    );

    clksel_pll #(.MOD_W(MOD_W)) u_pll (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (hit_mod),
        .prot_i    (prot_i),
        .pll_sel_i (pll_sel_o),
        .wdata_i   (wdata_i[MOD_W-1:0]),
        .mod_o     (pll_mod_o),
        .accept_o  (accept)
    );

    // Readback mux: unmapped addresses return zero.
    always_comb begin
        wdog_src_o = wd_src;
        if (addr_i == A_SEL)      rdata_o = DATA_W'(sel_rd);
        else if (addr_i == A_MOD) rdata_o = DATA_W'(pll_mod_o);
        else                      rdata_o = '0;
    end

    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i != A_SEL && addr_i != A_MOD) |-> (rdata_o == '0));

    p_wdog_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_src_o != 2'd3);
endmodule

// File: tb/clksel_ctrl_tb_top.sv
`timescale 1ns/1ps
module clksel_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr = 1'b0, prot = 1'b0, oset = 1'b0, lset = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       tick_src, trst, wrst, psel, osc, lock;
    logic [1:0] wsrc, mod;

    always #4 clk = ~clk;

    clksel_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .prot_i(prot), .osc_set_i(oset), .lock_set_i(lset),
        .tick_src_o(tick_src), .wdog_src_o(wsrc), .tick_restart_o(trst),
        .wdog_restart_o(wrst), .pll_mod_o(mod), .pll_sel_o(psel),
        .osc_up_o(osc), .pll_lock_o(lock)
    );

    typedef struct packed {
        logic [7:0] rd;
        logic       tick;
        logic [1:0] wsrc;
        logic       trst;
        logic       wrst;
        logic [1:0] mod;
        logic       psel;
        logic       osc;
        logic       lock;
    } obs_t;

    obs_t  exp_q[$];
    string tag_q[$];
    int    due_q[$];
    int    cyc = 0;
    int    checks = 0, errors = 0;
    bit    done = 0;
    obs_t  act;

    assign act = {rdata, tick_src, wsrc, trst, wrst, mod, psel, osc, lock};

    always @(posedge clk) cyc <= cyc + 1;

    // Scoreboard monitor: pops items falling due on this cycle and compares.
    always @(negedge clk) begin
        while (due_q.size() > 0 && due_q[0] == cyc) begin
            obs_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            void'(due_q.pop_front());
            checks++;
            if (act !== e) begin
                errors++;
                $display("FAIL %s: actual=%h expected=%h", t, act, e);
            end
        end
    end

    // Behavioural model built from the requirements.
    logic       m_tick = 0, m_lo = 0, m_hi = 0, m_psel = 0, m_osc = 0, m_lock = 0;
    logic [1:0] m_mod = 0;

    function automatic logic [1:0] code(input logic h, input logic l);
        return h ? 2'd2 : {1'b0, l};
    endfunction

    function automatic logic [7:0] rd_of(input logic [1:0] a);
        if (a == 2'd0) return {4'b0, m_psel, m_hi, m_tick, m_lo};
        if (a == 2'd1) return {6'b0, m_mod};
        return 8'h00;
    endfunction

    // Driver: applies one access for one edge, pushes the expected observation.
    task automatic step(input logic w, input logic [1:0] a, input logic [7:0] d,
                        input logic p, input logic os, input logic ls, input string tag);
        logic acc, osc_n, lock_n, tick_w, lo_w, tick_n, lo_n;
        logic [1:0] old_code;
        logic old_tick;
        obs_t e;
        @(posedge clk); #1;
        wr = w; addr = a; wdata = d; prot = p; oset = os; lset = ls;
        acc    = w && a == 2'd1 && !p && m_psel;
        osc_n  = acc ? 1'b0 : (os | m_osc);
        lock_n = acc ? 1'b0 : (ls | m_lock);
        tick_w = m_tick; lo_w = m_lo;
        old_code = code(m_hi, m_lo);
        old_tick = m_tick;
        if (w && a == 2'd0) begin
            tick_w = d[1] & m_osc;
            lo_w   = d[0] & m_osc;
            m_hi   = d[2];
            m_psel = d[3];
        end
        tick_n = tick_w & osc_n;
        lo_n   = lo_w & osc_n;
        if (acc) m_mod = d[1:0];
        m_tick = tick_n; m_lo = lo_n; m_osc = osc_n; m_lock = lock_n;
        e.rd   = rd_of(a);
        e.tick = m_tick;
        e.wsrc = code(m_hi, m_lo);
        e.trst = (m_tick != old_tick);
        e.wrst = (e.wsrc != old_code);
        e.mod  = m_mod;
        e.psel = m_psel;
        e.osc  = m_osc;
        e.lock = m_lock;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        due_q.push_back(cyc + 1);
        @(posedge clk); #1;
        wr = 1'b0; oset = 1'b0; lset = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        exp_q.push_back('0); tag_q.push_back("R1 reset state"); due_q.push_back(cyc);
        step(1, 0, 8'h02, 0, 0, 0, "R2 tick set refused while oscillator down");
        step(0, 0, 8'h00, 0, 1, 0, "R10 oscillator flag set");
        step(1, 0, 8'h02, 0, 0, 0, "R4 tick source change pulses restart");
        step(1, 0, 8'h03, 0, 0, 0, "R5 watchdog code oscillator");
        step(1, 0, 8'h07, 0, 0, 0, "R6 high select gives auxiliary with restart");
        step(1, 0, 8'h06, 0, 0, 0, "R6 low toggle under high gives no restart");
        step(1, 0, 8'h07, 0, 0, 0, "R6 low toggle back gives no restart");
        step(1, 1, 8'h03, 0, 0, 0, "R8 write ignored with synth select low");
        step(1, 0, 8'h0F, 0, 0, 0, "R2 synth select bit set");
        step(1, 1, 8'h02, 1, 0, 0, "R8 write ignored while protected");
        step(0, 1, 8'h00, 1, 0, 1, "R10 lock flag set");
        step(1, 1, 8'hFF, 0, 0, 0, "R7 R9 accepted write clears flags");
        step(0, 0, 8'h00, 0, 0, 0, "R3 oscillator bits cleared on drop");
        step(0, 0, 8'h00, 0, 1, 0, "R10 oscillator flag set again");
        step(1, 0, 8'h09, 0, 0, 0, "R5 auxiliary to oscillator code");
        step(1, 1, 8'h01, 0, 1, 1, "R9 clear beats set with forced clear R3");
        step(0, 2, 8'h00, 0, 0, 0, "R11 address 2 reads zero");
        step(1, 3, 8'hFF, 0, 0, 0, "R11 write to address 3 ignored");
        step(0, 0, 8'h00, 0, 0, 0, "R11 state unchanged after unmapped write");
        repeat (3) @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #40000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule